// File: doc/BRIEF.md
# Conversion Retry Pin Monitor

This block sits beside a bit-serial conversion engine. It watches an event input that marks a state change on a monitored pin. When such an event falls inside a bit cycle, the block decides whether that bit cycle must be run again. The conversion engine gives three timing inputs: one strobe when a conversion starts, one when it ends, and one strobe that closes each bit cycle. The block answers each closing strobe in the next cycle. It either pulses a repeat request or stays quiet, and staying quiet means the bit is accepted.

A 2-bit policy input selects how events are handled:

| Code | Behaviour |
|------|-----------|
| 0 | Repeat the bit cycle on every event. |
| 1 | Allow at most 2 back-to-back repeats of the same bit. |
| 2 | Allow at most 4 back-to-back repeats of the same bit. |
| 3 | Never repeat. |

A sticky flag shows whether any repeat was requested during the most recent conversion. Software or the engine can read it after the conversion ends to judge how reliable the result is.

Top module: `retry_pin_monitor`

## Requirements
- R1: After reset, `repeat_req` and `retry_flag` are both 0.
- R2: With policy code 0, every bit cycle that saw an event during an active conversion is followed by `repeat_req` high. The event may arrive anywhere from the bit cycle's start up to and including its `bit_end` cycle. `repeat_req` rises in the clock cycle right after the `bit_end` strobe.
- R3: With policy code 1, at most 2 repeats are granted back to back. A third eventful closing in a row is accepted, with no repeat.
- R4: With policy code 2, at most 4 repeats are granted back to back. A fifth eventful closing in a row is accepted.
- R5: With policy code 3, `repeat_req` never rises and `retry_flag` stays 0, whatever the events.
- R6: Any accepted bit cycle clears the back-to-back repeat count to zero. This covers a bit cycle with no event and one accepted at the cap. After the clear, the full cap is available again.
- R7: `retry_flag` rises in the same cycle as the first `repeat_req` of a conversion. It then holds, through `conv_end`, until the next `conv_start`. That `conv_start` clears it in the following cycle.
- R8: `repeat_req` is a one-cycle pulse, provided `bit_end` strobes are at least two cycles apart.
- R9: Events and `bit_end` strobes that occur while no conversion is active never cause a repeat. An event is forgotten once its bit cycle closes.
- R10: `conv_start` clears the repeat count. A repeat count left over from an earlier conversion therefore does not shorten the cap of the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Retry policy code: 0 always, 1 cap at 2, 2 cap at 4, 3 never |
| conv_start | input | 1 | One-cycle strobe: a conversion begins |
| conv_end | input | 1 | One-cycle strobe: the conversion has finished |
| bit_end | input | 1 | One-cycle strobe closing the current bit cycle |
| pin_evt | input | 1 | Pin state change event |
| repeat_req | output | 1 | One-cycle pulse: run the bit cycle just closed again |
| retry_flag | output | 1 | Sticky: at least one repeat was requested in the last conversion |

## Verification
The bench drives runs of eventful bit cycles longer than each cap.

- An off-by-one in the limit compare would show up as a third repeat under policy 1, or as only three repeats under policy 2.
- A counter that is not cleared by a clean bit, or by a new conversion, would deny repeats that should be granted.
- A flag cleared at `conv_end` would read 0 after the conversion, and one never cleared would read 1 at the next start.
- Events sent while idle, and a bit cycle closed after an earlier event, catch a latch that leaks across bit cycles or ignores the active window.

// File: rtl/retry_pin_monitor_pkg.sv
`timescale 1ns/1ps
package retry_pin_monitor_pkg;

  typedef enum logic [1:0] {
    POL_ALWAYS = 2'd0,
    POL_CAP_LO = 2'd1,
    POL_CAP_HI = 2'd2,
    POL_IGNORE = 2'd3
  } retry_pol_e;

  // May one more repeat be granted, given the repeats already used in a row?
  function automatic logic retry_allowed(input retry_pol_e pol,
                                         input int unsigned used,
                                         input int unsigned lim_lo,
                                         input int unsigned lim_hi);
    case (pol)
      POL_ALWAYS: retry_allowed = 1'b1;
      POL_CAP_LO: retry_allowed = (used < lim_lo);
      POL_CAP_HI: retry_allowed = (used < lim_hi);
      default:    retry_allowed = 1'b0;
    endcase
  endfunction

  // Next repeat count: grows on a grant (saturating), clears on acceptance.
  function automatic int unsigned next_count(input logic granted,
                                             input int unsigned used,
                                             input int unsigned cap);
    if (!granted)        next_count = 0;
    else if (used >= cap) next_count = cap;
    else                 next_count = used + 1;
  endfunction

endpackage

// File: rtl/rpm_event_latch.sv
`timescale 1ns/1ps
module rpm_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic flush,
  input  logic pin_evt,
  output logic evt_hit
);
  logic pend_q;

  // An event in the closing cycle itself still belongs to that bit cycle.
  assign evt_hit = pend_q | (active & pin_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (flush)  pend_q <= 1'b0;
    else if (active && pin_evt) pend_q <= 1'b1;
  end
endmodule

// File: rtl/rpm_retry_ctrl.sv
`timescale 1ns/1ps
module rpm_retry_ctrl
  import retry_pin_monitor_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int LIM_LO = 2,
  parameter int LIM_HI = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start,
  input  logic             close_bit,
  input  logic             evt_hit,
  input  retry_pol_e       pol,
  output logic             grant,
  output logic             repeat_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic             may_retry;
  int unsigned      cnt_nx;

  assign may_retry = retry_allowed(pol, 32'(cnt_q), LIM_LO, LIM_HI);
  assign grant     = close_bit & evt_hit & may_retry & ~conv_start;
  assign cnt_nx    = next_count(grant, 32'(cnt_q), CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      repeat_q <= 1'b0;
    end else begin
      repeat_q <= grant;
      if (conv_start)     cnt_q <= '0;
      else if (close_bit) cnt_q <= cnt_nx[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rpm_flag.sv
`timescale 1ns/1ps
module rpm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (clr) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
  end
endmodule

// File: rtl/retry_pin_monitor.sv
`timescale 1ns/1ps
module retry_pin_monitor
  import retry_pin_monitor_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int LIM_LO = 2,
  parameter int LIM_HI = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy,
  input  logic       conv_start,
  input  logic       conv_end,
  input  logic       bit_end,
  input  logic       pin_evt,
  output logic       repeat_req,
  output logic       retry_flag
);
  logic             active_q;
  logic             close_bit;
  logic             evt_hit;
  logic             grant;
  logic             flush;
  logic [CNT_W-1:0] cnt_q;
  retry_pol_e       pol;

  assign pol       = retry_pol_e'(policy);
  assign close_bit = bit_end & active_q;
  assign flush     = conv_start | conv_end | bit_end;

  // conv_start wins over conv_end if both arrive together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          active_q <= 1'b0;
    else if (conv_start) active_q <= 1'b1;
    else if (conv_end)   active_q <= 1'b0;
  end

  rpm_event_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active_q),
    .flush   (flush),
    .pin_evt (pin_evt),
    .evt_hit (evt_hit)
  );

  rpm_retry_ctrl #(
    .CNT_W  (CNT_W),
    .LIM_LO (LIM_LO),
    .LIM_HI (LIM_HI)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start),
    .close_bit  (close_bit),
    .evt_hit    (evt_hit),
    .pol        (pol),
    .grant      (grant),
    .repeat_q   (repeat_req),
    .cnt_q      (cnt_q)
  );

  rpm_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (conv_start),
    .set    (grant),
    .flag_q (retry_flag)
  );
endmodule

// File: rtl/retry_pin_monitor_checker.sv
`timescale 1ns/1ps
module retry_pin_monitor_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] policy,
  input logic       conv_start,
  input logic       bit_end,
  input logic       active_q,
  input logic       repeat_req,
  input logic       retry_flag
);
  assert_rep_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_req |-> $past(bit_end));

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_req |=> !repeat_req);

  assert_ignore_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && policy == 2'd3) |=> !repeat_req);

  assert_flag_with_rep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_req |-> retry_flag);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_flag && !conv_start) |=> retry_flag);

  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> (!retry_flag && !repeat_req));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_req |-> $past(active_q));
endmodule

bind retry_pin_monitor retry_pin_monitor_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .policy     (policy),
  .conv_start (conv_start),
  .bit_end    (bit_end),
  .active_q   (active_q),
  .repeat_req (repeat_req),
  .retry_flag (retry_flag)
);

// File: tb/retry_pin_monitor_bench.sv
`timescale 1ns/1ps
module retry_pin_monitor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] policy = 2'd0;
  logic       conv_start = 1'b0, conv_end = 1'b0, bit_end = 1'b0, pin_evt = 1'b0;
  logic       repeat_req, retry_flag;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // bench-side model state
  int  m_cnt = 0;
  bit  m_active = 0;
  bit  m_flag = 0;
  int  m_pol = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  retry_pin_monitor u_retry_pin_monitor (
    .clk(clk), .rst_n(rst_n), .policy(policy), .conv_start(conv_start),
    .conv_end(conv_end), .bit_end(bit_end), .pin_evt(pin_evt),
    .repeat_req(repeat_req), .retry_flag(retry_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic start_conv(input int pol);
    @(negedge clk);
    policy = 2'(pol); conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    m_pol = pol; m_cnt = 0; m_flag = 0; m_active = 1;
  endtask

  task automatic end_conv();
    @(negedge clk);
    conv_end = 1'b1;
    @(negedge clk);
    conv_end = 1'b0;
    m_active = 0;
  endtask

  // One bit cycle: optional event, then the closing strobe; expected answer queued.
  task automatic do_bit(input bit ev, input string req);
    int lim;
    bit exp;
    lim = (m_pol == 1) ? 2 : 4;
    exp = m_active && ev && (m_pol == 0 || ((m_pol == 1 || m_pol == 2) && m_cnt < lim));
    if (m_active) m_cnt = exp ? m_cnt + 1 : 0;
    if (exp) m_flag = 1;
    @(negedge clk); pin_evt = ev;
    @(negedge clk); pin_evt = 1'b0;
    @(negedge clk); bit_end = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); bit_end = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: compares repeat_req one cycle after each closing strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (bit_end && rst_n) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R2: actual unexpected strobe expected none");
        end else begin
          automatic bit e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, repeat_req, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", repeat_req, 1'b0);
    chk("R1", retry_flag, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: policy 0 repeats every eventful bit
    start_conv(0);
    for (int i = 0; i < 5; i++) do_bit(1'b1, "R2");
    do_bit(1'b0, "R6");
    chk("R7", retry_flag, 1'b1);
    end_conv();
    repeat (3) @(negedge clk);
    chk("R7", retry_flag, 1'b1);

    // R9: idle events ignored
    do_bit(1'b1, "R9");
    chk("R9", retry_flag, 1'b1);

    // R3 / R6: policy 1 cap, clean bit resets count
    start_conv(1);
    chk("R7", retry_flag, 1'b0);
    do_bit(1'b1, "R3"); do_bit(1'b1, "R3"); do_bit(1'b1, "R3");
    do_bit(1'b1, "R6"); do_bit(1'b0, "R6"); do_bit(1'b1, "R6");
    do_bit(1'b1, "R6"); do_bit(1'b1, "R3");
    // event then clean close: event must not carry into the next bit (R9)
    do_bit(1'b0, "R9");
    end_conv();

    // R4: policy 2 cap at four
    start_conv(2);
    for (int i = 0; i < 6; i++) do_bit(1'b1, "R4");
    chk("R7", retry_flag, 1'b1);
    end_conv();

    // R5: policy 3 never repeats
    start_conv(3);
    for (int i = 0; i < 3; i++) do_bit(1'b1, "R5");
    chk("R5", retry_flag, 1'b0);
    end_conv();

    // R10: leftover count cleared by a new start
    start_conv(1);
    do_bit(1'b1, "R10");
    start_conv(1);
    do_bit(1'b1, "R10"); do_bit(1'b1, "R10"); do_bit(1'b1, "R10");
    end_conv();

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule